// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one configurable cell of a small programmable logic device. A configuration word, loaded once through a write port, sets every mode of the cell. The cell takes a sum-of-products value from an external product-term array and XORs it with one more product term. It can then invert the result. That logic value either goes straight to the outputs or feeds a storage element. The storage element can act as a D flip-flop, a T flip-flop or a transparent latch.

The storage element can be clocked from one of the global clocks, from a clock term shared by the function block, or from a local product term. It can use one chosen edge or both edges. Asynchronous set and reset each have their own source select. In input-register mode the storage element captures the pad input instead. The logic value then stays available as a separate buried feedback.

Top module: `plm_cell`

## Requirements
- R1: `fb_buried` always equals `sop_in ^ pt_xor`, inverted when configuration bit 0 is 1.
- R2: When configuration bit 1 is 0 and bit 15 is 0, both `io_data` and `fb_main` carry the logic value of R1. When bit 1 is 1, both carry the stored value.
- R3: Configuration bits [3:2] select the storage kind. 0 is a D flip-flop. 1 is a T flip-flop, which inverts on an active edge when its data is 1 and holds when its data is 0. 2 is a latch that is transparent while the effective clock is 1. 3 never changes except through set and reset.
- R4: When bit 13 is 1, a low `pt_ce` makes a D flip-flop hold through active edges. T mode ignores `pt_ce`.
- R5: When bit 4 is 1, both clock edges are active. Otherwise the effective clock is the selected clock XOR bit 5, and only its rising edge is active.
- R6: Bits [8:6] select the clock. Values 0 to 2 pick `gclk[0..2]`, 3 picks `ct_clk`, 4 picks `pt_clk`, and 5 to 7 pick a constant 0.
- R7: Set source is bits [10:9] and reset source is bits [12:11]. For each field, 0 means never, 1 means the local term (`pt_set` / `pt_rst`), 2 means the shared term (`ct_set` / `ct_rst`), and 3 means `gsr`. Both act at once, without a clock edge.
- R8: When set and reset are active together, the stored value is 0.
- R9: When bit 15 is 1, the storage element captures `pad_in`, `fb_main` shows the stored value, and `io_data` shows the logic value.
- R10: `io_oe` follows `pt_oe` when bit 14 is 0 and `ct_oe` when bit 14 is 1.
- R11: `cfg_wdata` is loaded at a rising `clk` edge when `cfg_we` is 1 and `cfg_valid` is 0. The write is ignored while `cfg_valid` is 1. A low `rst_n` at a rising edge clears the word to 0.
- R12: The stored value is held at 0 while `cfg_valid` is 0, so the cell starts cleared once the configuration becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock for the configuration register |
| rst_n | input | 1 | synchronous active-low reset of the configuration |
| cfg_valid | input | 1 | configuration is in force; writes are locked |
| cfg_we | input | 1 | configuration write strobe |
| cfg_wdata | input | 16 | configuration word |
| gclk | input | 3 | global clocks |
| gsr | input | 1 | global set/reset |
| ct_clk | input | 1 | shared clock term of the function block |
| ct_set | input | 1 | shared set term |
| ct_rst | input | 1 | shared reset term |
| ct_oe | input | 1 | shared output-enable term |
| sop_in | input | 1 | sum-of-products value |
| pt_xor | input | 1 | single product term for the XOR |
| pt_clk | input | 1 | local clock term |
| pt_set | input | 1 | local set term |
| pt_rst | input | 1 | local reset term |
| pt_ce | input | 1 | local clock-enable term |
| pt_oe | input | 1 | local output-enable term |
| pad_in | input | 1 | pad input for input-register mode |
| io_data | output | 1 | data toward the pad driver |
| io_oe | output | 1 | output enable toward the pad driver |
| fb_main | output | 1 | feedback to the interconnect |
| fb_buried | output | 1 | buried logic feedback |

## Verification
The asynchronous set and the asynchronous reset can be active in the same cycle. The bench first selects a local set and a global reset. It raises the local set term and sees the stored value go to 1 with no clock edge. It then raises the global reset while the set term is still high, and expects the stored value to read 0 at once. A property also watches every cycle in which both lines are active.

// File: rtl/plm_pkg.sv
// Shared types and sizes for the configurable logic cell.
// Assumes three global clocks, which gives a 3-bit clock-source field.
package plm_pkg;
    localparam int NUM_GCLK = 3;
    localparam int CSRC_W   = $clog2(NUM_GCLK + 2);

    typedef enum logic [1:0] {
        ST_D     = 2'd0,
        ST_T     = 2'd1,
        ST_LATCH = 2'd2,
        ST_HOLD  = 2'd3
    } store_e;

    typedef enum logic [1:0] {
        AS_NONE   = 2'd0,
        AS_LOCAL  = 2'd1,
        AS_SHARED = 2'd2,
        AS_GLOBAL = 2'd3
    } async_src_e;

    typedef struct packed {
        logic              in_reg;
        logic              oe_shared;
        logic              ce_on;
        async_src_e        rst_src;
        async_src_e        set_src;
        logic [CSRC_W-1:0] clk_src;
        logic              clk_inv;
        logic              both_edge;
        store_e            store;
        logic              registered;
        logic              invert;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/plm_cfg_reg.sv
// Holds the static configuration word of the cell.
// Assumes writes come only while the configuration is not yet valid.
module plm_cfg_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_valid,
    input  logic         cfg_we,
    input  logic [W-1:0] cfg_wdata,
    output logic [W-1:0] cfg_q
);
    // Load on an unlocked write; clear on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we && !cfg_valid)
            cfg_q <= cfg_wdata;
    end
endmodule

// File: rtl/plm_src_sel.sv
// Picks the clock, async set, async reset, clock enable, data and output
// enable of the cell from the configuration.
// Assumes clk_src values above NUM_GCLK+1 mean a constant-low clock.
module plm_src_sel
    import plm_pkg::*;
(
    input  cfg_t                cfg,
    input  logic                cfg_valid,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                gsr,
    input  logic                ct_clk,
    input  logic                ct_set,
    input  logic                ct_rst,
    input  logic                ct_oe,
    input  logic                pt_clk,
    input  logic                pt_set,
    input  logic                pt_rst,
    input  logic                pt_ce,
    input  logic                pt_oe,
    input  logic                pad_in,
    input  logic                logic_val,
    output logic                ck_eff,
    output logic                set_line,
    output logic                clr_line,
    output logic                ce_line,
    output logic                d_line,
    output logic                oe_line
);
    logic clk_raw;

    function automatic logic pick_async(async_src_e s, logic loc, logic shr, logic glb);
        case (s)
            AS_LOCAL:  return loc;
            AS_SHARED: return shr;
            AS_GLOBAL: return glb;
            default:   return 1'b0;
        endcase
    endfunction

    // Clock source mux over global, shared and local terms.
    always_comb begin
        clk_raw = 1'b0;
        for (int i = 0; i < NUM_GCLK; i++)
            if (int'(cfg.clk_src) == i) clk_raw = gclk[i];
        if (int'(cfg.clk_src) == NUM_GCLK)     clk_raw = ct_clk;
        if (int'(cfg.clk_src) == NUM_GCLK + 1) clk_raw = pt_clk;
    end

    // Polarity, async controls, enable, data and output-enable selection.
    always_comb begin
        ck_eff   = clk_raw ^ cfg.clk_inv;
        set_line = pick_async(cfg.set_src, pt_set, ct_set, gsr);
        clr_line = pick_async(cfg.rst_src, pt_rst, ct_rst, gsr) | ~cfg_valid;
        ce_line  = cfg.ce_on ? pt_ce : 1'b1;
        d_line   = cfg.in_reg ? pad_in : logic_val;
        oe_line  = cfg.oe_shared ? ct_oe : pt_oe;
    end
endmodule

// File: rtl/plm_store.sv
// Storage element: D or T flip-flop on one or both edges, or a transparent
// latch, with async set and clear where clear wins.
// Assumes ck is the polarity-corrected clock (active edge is rising).
module plm_store
    import plm_pkg::*;
(
    input  logic   ck,
    input  logic   both_edge,
    input  store_e mode,
    input  logic   ce,
    input  logic   d,
    input  logic   set_a,
    input  logic   clr_a,
    output logic   q
);
    logic q_edge;
    logic q_lat;

    // Edge-triggered path; a falling event counts only in both-edge mode.
    always_ff @(posedge ck or negedge ck or posedge clr_a or posedge set_a) begin
        if (clr_a)
            q_edge <= 1'b0;
        else if (set_a)
            q_edge <= 1'b1;
        else if (both_edge || ck) begin
            case (mode)
                ST_D:    if (ce) q_edge <= d;
                ST_T:    if (d) q_edge <= ~q_edge;
                default: q_edge <= q_edge;
            endcase
        end
    end

    // Level-sensitive path, transparent while ck is high in latch mode.
    always_latch begin
        if (clr_a)
            q_lat = 1'b0;
        else if (set_a)
            q_lat = 1'b1;
        else if (mode == ST_LATCH && ck)
            q_lat = d;
    end

    // Present the path that matches the storage kind.
    assign q = (mode == ST_LATCH) ? q_lat : q_edge;
endmodule

// File: rtl/plm_cell.sv
// Top of the configurable logic cell: XOR/polarity logic, source selection,
// storage and output routing.
// Assumes configuration is written only while cfg_valid is low.
module plm_cell
    import plm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_valid,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                gsr,
    input  logic                ct_clk,
    input  logic                ct_set,
    input  logic                ct_rst,
    input  logic                ct_oe,
    input  logic                sop_in,
    input  logic                pt_xor,
    input  logic                pt_clk,
    input  logic                pt_set,
    input  logic                pt_rst,
    input  logic                pt_ce,
    input  logic                pt_oe,
    input  logic                pad_in,
    output logic                io_data,
    output logic                io_oe,
    output logic                fb_main,
    output logic                fb_buried
);
    logic [CFG_W-1:0] cfg_word;
    cfg_t             cfg;
    logic             logic_val;
    logic             ck_eff, set_line, clr_line, ce_line, d_line, oe_line;
    logic             store_q;

    plm_cfg_reg #(.W(CFG_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_word)
    );

    // Reinterpret the raw word as named fields and form the logic value.
    always_comb begin
        cfg       = cfg_t'(cfg_word);
        logic_val = sop_in ^ pt_xor ^ cfg.invert;
    end

    plm_src_sel i_sel (
        .cfg(cfg), .cfg_valid(cfg_valid), .gclk(gclk), .gsr(gsr),
        .ct_clk(ct_clk), .ct_set(ct_set), .ct_rst(ct_rst), .ct_oe(ct_oe),
        .pt_clk(pt_clk), .pt_set(pt_set), .pt_rst(pt_rst), .pt_ce(pt_ce),
        .pt_oe(pt_oe), .pad_in(pad_in), .logic_val(logic_val),
        .ck_eff(ck_eff), .set_line(set_line), .clr_line(clr_line),
        .ce_line(ce_line), .d_line(d_line), .oe_line(oe_line)
    );

    plm_store i_store (
        .ck(ck_eff), .both_edge(cfg.both_edge), .mode(cfg.store),
        .ce(ce_line), .d(d_line), .set_a(set_line), .clr_a(clr_line),
        .q(store_q)
    );

    // Route logic value or stored value to pad and feedback outputs.
    always_comb begin
        fb_buried = logic_val;
        io_oe     = oe_line;
        if (cfg.in_reg) begin
            io_data = logic_val;
            fb_main = store_q;
        end else begin
            io_data = cfg.registered ? store_q : logic_val;
            fb_main = cfg.registered ? store_q : logic_val;
        end
    end
endmodule

// File: rtl/plm_cell_chk.sv
// Property checker for plm_cell, attached by bind.
// Assumes asynchronous inputs settle away from rising clk edges.
module plm_cell_chk
    import plm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_valid,
    input logic [CFG_W-1:0] cfg_word,
    input logic             set_line,
    input logic             clr_line,
    input logic             store_q,
    input logic             io_data,
    input logic             io_oe,
    input logic             ct_oe,
    input logic             fb_main,
    input logic             fb_buried
);
    cfg_t c;
    assign c = cfg_t'(cfg_word);

    a_r8_clear_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_line && clr_line) |-> (store_q == 1'b0));

    a_r12_cleared_while_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (store_q == 1'b0));

    a_r11_locked_config: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_valid) |-> $stable(cfg_word));

    a_r2_bypass_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        (!c.registered && !c.in_reg) |-> (fb_main == fb_buried));

    a_r9_pad_keeps_logic: assert property (@(posedge clk) disable iff (!rst_n)
        c.in_reg |-> (io_data == fb_buried));

    a_r10_shared_oe: assert property (@(posedge clk) disable iff (!rst_n)
        c.oe_shared |-> (io_oe == ct_oe));
endmodule

bind plm_cell plm_cell_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .set_line(set_line), .clr_line(clr_line), .store_q(store_q),
    .io_data(io_data), .io_oe(io_oe), .ct_oe(ct_oe),
    .fb_main(fb_main), .fb_buried(fb_buried)
);

// File: tb/test_plm_cell.sv
// Directed bench for plm_cell: one task per scenario, each checking itself.
module test_plm_cell;
    logic        clk = 1'b0;
    logic        rst_n, cfg_valid, cfg_we;
    logic [15:0] cfg_wdata;
    logic [2:0]  gclk;
    logic        gsr, ct_clk, ct_set, ct_rst, ct_oe;
    logic        sop_in, pt_xor, pt_clk, pt_set, pt_rst, pt_ce, pt_oe, pad_in;
    logic        io_data, io_oe, fb_main, fb_buried;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    plm_cell i_plm_cell (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .gclk(gclk), .gsr(gsr), .ct_clk(ct_clk),
        .ct_set(ct_set), .ct_rst(ct_rst), .ct_oe(ct_oe), .sop_in(sop_in),
        .pt_xor(pt_xor), .pt_clk(pt_clk), .pt_set(pt_set), .pt_rst(pt_rst),
        .pt_ce(pt_ce), .pt_oe(pt_oe), .pad_in(pad_in), .io_data(io_data),
        .io_oe(io_oe), .fb_main(fb_main), .fb_buried(fb_buried)
    );

    function automatic logic [15:0] mk(input int store = 0, input int csrc = 0,
            input bit regd = 1, input bit inv = 0, input bit cinv = 0,
            input bit both = 0, input int ssrc = 0, input int rsrc = 0,
            input bit ce = 0, input bit oesh = 0, input bit inreg = 0);
        return {inreg, oesh, ce, 2'(rsrc), 2'(ssrc), 3'(csrc), cinv, both,
                2'(store), regd, inv};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply a change just after a falling clk edge; results settle 1 ns later.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        step();
        gclk = '0; gsr = 0; ct_clk = 0; ct_set = 0; ct_rst = 0; ct_oe = 0;
        sop_in = 0; pt_xor = 0; pt_clk = 0; pt_set = 0; pt_rst = 0;
        pt_ce = 0; pt_oe = 0; pad_in = 0;
    endtask

    task automatic load(input logic [15:0] w);
        step(); cfg_valid = 0; cfg_we = 1; cfg_wdata = w;
        step(); cfg_we = 0; cfg_valid = 1; #1;
    endtask

    task automatic g0(input logic v);
        step(); gclk[0] = v; #1;
    endtask

    task automatic t_reset();
        rst_n = 0; cfg_valid = 0; cfg_we = 0; cfg_wdata = '0;
        quiet();
        repeat (3) step();
        rst_n = 1; cfg_valid = 1;
        step(); sop_in = 1; pt_oe = 1; #1;
        chk("R11 reset word gives bypass", io_data, 1'b1);
        chk("R11 reset word feedback", fb_main, 1'b1);
        chk("R10 local oe after reset", io_oe, 1'b1);
    endtask

    task automatic t_logic();
        for (int inv = 0; inv < 2; inv++) begin
            quiet();
            load(mk(.regd(0), .inv(inv[0])));
            for (int v = 0; v < 4; v++) begin
                step(); sop_in = v[0]; pt_xor = v[1]; #1;
                chk("R1 logic value", fb_buried, v[0] ^ v[1] ^ inv[0]);
                chk("R2 bypass io_data", io_data, v[0] ^ v[1] ^ inv[0]);
            end
        end
    endtask

    task automatic t_dff();
        quiet(); load(mk(.store(0)));
        step(); sop_in = 1; #1;
        chk("R2 registered starts 0", fb_main, 1'b0);
        g0(1); chk("R3 D rising loads", fb_main, 1'b1);
        chk("R2 io_data is stored", io_data, 1'b1);
        step(); sop_in = 0; #1;
        g0(0); chk("R5 falling ignored", fb_main, 1'b1);
        g0(1); chk("R3 D loads 0", fb_main, 1'b0);
        quiet(); load(mk(.store(0), .cinv(1)));
        step(); sop_in = 1; #1;
        g0(1); chk("R5 inverted: rise ignored", fb_main, 1'b0);
        g0(0); chk("R5 inverted: fall loads", fb_main, 1'b1);
    endtask

    task automatic t_dual();
        quiet(); load(mk(.store(0), .both(1)));
        step(); sop_in = 1; #1;
        g0(1); chk("R5 both: rise", fb_main, 1'b1);
        step(); sop_in = 0; #1;
        g0(0); chk("R5 both: fall", fb_main, 1'b0);
    endtask

    task automatic t_tff();
        quiet(); load(mk(.store(1)));
        step(); sop_in = 1; #1;
        g0(1); chk("R3 T toggles up", fb_main, 1'b1);
        g0(0); g0(1); chk("R3 T toggles down", fb_main, 1'b0);
        step(); sop_in = 0; #1;
        g0(0); g0(1); chk("R3 T holds on 0", fb_main, 1'b0);
        quiet(); load(mk(.store(1), .ce(1)));
        step(); sop_in = 1; pt_ce = 0; #1;
        g0(1); chk("R4 T ignores enable", fb_main, 1'b1);
    endtask

    task automatic t_ce();
        quiet(); load(mk(.store(0), .ce(1)));
        step(); sop_in = 1; pt_ce = 0; #1;
        g0(1); chk("R4 D holds when disabled", fb_main, 1'b0);
        step(); pt_ce = 1; #1;
        g0(0); g0(1); chk("R4 D loads when enabled", fb_main, 1'b1);
    endtask

    task automatic t_latch();
        quiet(); load(mk(.store(2)));
        step(); sop_in = 1; #1;
        chk("R3 latch opaque", fb_main, 1'b0);
        g0(1); chk("R3 latch opens", fb_main, 1'b1);
        step(); sop_in = 0; #1;
        chk("R3 latch follows", fb_main, 1'b0);
        g0(0);
        step(); sop_in = 1; #1;
        chk("R3 latch holds", fb_main, 1'b0);
        quiet(); load(mk(.store(3)));
        step(); sop_in = 1; #1;
        g0(1); chk("R3 hold kind never loads", fb_main, 1'b0);
    endtask

    task automatic t_clksrc();
        quiet(); load(mk(.csrc(3)));
        step(); sop_in = 1; #1;
        g0(1); chk("R6 gclk0 unused", fb_main, 1'b0);
        step(); ct_clk = 1; #1;
        chk("R6 shared clock", fb_main, 1'b1);
        quiet(); load(mk(.csrc(4)));
        step(); sop_in = 1; #1;
        step(); pt_clk = 1; #1;
        chk("R6 local clock", fb_main, 1'b1);
        quiet(); load(mk(.csrc(5)));
        step(); sop_in = 1; #1;
        step(); gclk = '1; ct_clk = 1; pt_clk = 1; #1;
        chk("R6 code 5 is constant", fb_main, 1'b0);
    endtask

    task automatic t_async();
        quiet(); load(mk(.ssrc(1), .rsrc(2)));
        step(); pt_set = 1; #1;
        chk("R7 local set", fb_main, 1'b1);
        step(); pt_set = 0; #1;
        step(); ct_rst = 1; #1;
        chk("R7 shared reset", fb_main, 1'b0);
        quiet(); load(mk(.ssrc(0), .rsrc(0)));
        step(); pt_set = 1; ct_set = 1; gsr = 1; #1;
        chk("R7 no source ignores terms", fb_main, 1'b0);
        quiet(); load(mk(.ssrc(3)));
        step(); gsr = 1; #1;
        chk("R7 global as set", fb_main, 1'b1);
        quiet(); load(mk(.ssrc(1), .rsrc(3)));
        step(); pt_set = 1; #1;
        chk("R8 set alone", fb_main, 1'b1);
        step(); gsr = 1; #1;
        chk("R8 reset wins", fb_main, 1'b0);
        step(); pt_set = 0; #1;
        step(); gsr = 0; #1;
    endtask

    task automatic t_inreg();
        quiet(); load(mk(.regd(0), .inreg(1)));
        step(); pad_in = 1; #1;
        chk("R9 logic on io_data", io_data, 1'b0);
        g0(1); chk("R9 pad captured", fb_main, 1'b1);
        step(); pad_in = 0; sop_in = 1; #1;
        chk("R9 buried logic", fb_buried, 1'b1);
        chk("R9 io_data follows logic", io_data, 1'b1);
        chk("R9 stored pad kept", fb_main, 1'b1);
    endtask

    task automatic t_oe();
        quiet(); load(mk(.oesh(0)));
        step(); pt_oe = 0; ct_oe = 1; #1;
        chk("R10 local oe", io_oe, 1'b0);
        quiet(); load(mk(.oesh(1)));
        step(); pt_oe = 1; ct_oe = 0; #1;
        chk("R10 shared oe low", io_oe, 1'b0);
        step(); ct_oe = 1; #1;
        chk("R10 shared oe high", io_oe, 1'b1);
    endtask

    task automatic t_cfg();
        quiet(); load(mk(.store(0)));
        step(); sop_in = 1; #1;
        g0(1);
        step(); cfg_we = 1; cfg_wdata = mk(.regd(0));
        step(); cfg_we = 0; sop_in = 0; #1;
        chk("R11 write ignored while valid", fb_main, 1'b1);
        step(); cfg_valid = 0; #1;
        chk("R12 cleared on invalid", fb_main, 1'b0);
        step(); sop_in = 1; #1;
        g0(0); g0(1);
        chk("R12 stays clear", fb_main, 1'b0);
        step(); cfg_valid = 1; #1;
        chk("R12 starts clear when valid", fb_main, 1'b0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_logic();
        t_dff();
        t_dual();
        t_tff();
        t_ce();
        t_latch();
        t_clksrc();
        t_async();
        t_inreg();
        t_oe();
        t_cfg();
        finish_up();
    end

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end
endmodule